// File: doc/BRIEF.md
# Serial Command Shift-Latch Interface

This block accepts a 16-bit control word for one pair of motor phases over a serial data line and a shift clock. It places the word in a shift register, and a rising edge on the strobe copies the word into a holding latch. The latch drives the control fields for the output stage: a torque scale code, and for each of the two phases a current code, a decay-select bit, a mixed-decay switch-point bit and a polarity bit. For each phase, an all-off flag goes high when the current code of that phase is zero.

The shift clock and the strobe are sampled on the system clock `clk_i`. An input counts as rising on the clock edge where it is first seen high after being seen low. The active-low reset clears both registers and forces every field off. A thermal-fault flag also forces the fields off, but it leaves the held word intact, so the old command returns when the fault clears.

Top module: `shl_serial_latch`

## Requirements
- R1: While `rst_ni` is low, the shift register and the latch are cleared. All fields read zero, both off flags read 1 and the torque scale reads 50. The same state remains after release until a word is strobed in.
- R2: On each detected rising edge of `sclk_i`, `sdata_i` is shifted in. After 16 edges the first bit sits at word bit 0 and the sixteenth bit sits at bit 15.
- R3: The latch loads only on a detected rising edge of `strobe_i`. A strobe held high, or shifting done without a strobe edge, leaves the outputs unchanged.
- R4: When more than 16 shift edges occur before a strobe, the oldest bits are dropped and only the last 16 bits received are latched.
- R5: While `thermal_i` is high, every field is forced off: all fields read zero and both off flags read 1.
- R6: While `thermal_i` is high, strobe edges do not load the latch. The held word reappears on the outputs once `thermal_i` falls.
- R7: The torque code is word bits [1:0]. `torque_pct_o` reads 100 for code 11, 85 for 10, 70 for 01 and 50 for 00.
- R8: A phase whose 4-bit current code is 0000 has its off flag at 1. Any nonzero code gives 0.
- R9: Each phase has a switch-point bit. When the bit is 1, `mix_pct_*_o` reads 74; when it is 0, it reads 40.
- R10: The word layout is as follows. Bits [1:0] hold the torque code. Phase B uses bit 2 for switch point, bit 3 for decay, bits [7:4] for current and bit 8 for polarity. Phase A uses bit 9 for switch point, bit 10 for decay, bits [14:11] for current and bit 15 for polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data bit |
| sclk_i | input | 1 | Shift clock, rising edge shifts |
| strobe_i | input | 1 | Transfer strobe, rising edge latches |
| thermal_i | input | 1 | Thermal fault: force off, freeze latch |
| torque_o | output | 2 | Torque code |
| torque_pct_o | output | 7 | Reference scale in percent |
| cur_a_o | output | 4 | Phase A current code |
| decay_a_o | output | 1 | Phase A decay select |
| mix_a_o | output | 1 | Phase A switch-point bit |
| mix_pct_a_o | output | 7 | Phase A switch point in percent of cycle |
| pol_a_o | output | 1 | Phase A polarity |
| off_a_o | output | 1 | Phase A bridge off |
| cur_b_o | output | 4 | Phase B current code |
| decay_b_o | output | 1 | Phase B decay select |
| mix_b_o | output | 1 | Phase B switch-point bit |
| mix_pct_b_o | output | 7 | Phase B switch point in percent of cycle |
| pol_b_o | output | 1 | Phase B polarity |
| off_b_o | output | 1 | Phase B bridge off |

## Verification
The hardest case to reach from the ports is the latch freeze during a thermal fault. While the fault is active the outputs are all forced to zero, so the frozen content cannot be seen. The stimulus therefore latches one word, raises the fault, and shifts and strobes a different word. It then drops the fault and checks that the first word returns. A second strobe follows, which shows that the shift register kept the second word. Overrun is reached by shifting 20 bits before a strobe. A strobe held high through a whole shift shows that strobe level has no effect.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int WORD_W = 16;
  localparam int CUR_W  = 4;
  localparam int TQ_W   = 2;
  localparam int NUM_PH = 2;
  localparam int PCT_W  = 7;

  // Field order is behaviour: bit 0 arrives first.
  typedef struct packed {
    logic             pol;
    logic [CUR_W-1:0] cur;
    logic             dec;
    logic             mix;
  } phase_t;

  typedef struct packed {
    phase_t          ph_a;
    phase_t          ph_b;
    logic [TQ_W-1:0] tq;
  } word_t;

  localparam int PH_W = $bits(phase_t);

  function automatic logic [PCT_W-1:0] torque_pct(input logic [TQ_W-1:0] code);
    case (code)
      2'b11:   torque_pct = PCT_W'(100);
      2'b10:   torque_pct = PCT_W'(85);
      2'b01:   torque_pct = PCT_W'(70);
      default: torque_pct = PCT_W'(50);
    endcase
  endfunction

  function automatic logic [PCT_W-1:0] mix_pct(input logic sel);
    mix_pct = sel ? PCT_W'(74) : PCT_W'(40);
  endfunction
endpackage

// File: rtl/shl_edge_det.sv
module shl_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/shl_shift_reg.sv
module shl_shift_reg #(
  parameter int WORD_W = shl_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;

  // Enter at MSB so the first bit ends at bit 0.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {data_i, sr_q[WORD_W-1:1]};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/shl_hold_latch.sv
module shl_hold_latch #(
  parameter int WORD_W = shl_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              freeze_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hold_q <= '0;
    else if (load_i && !freeze_i) hold_q <= word_i;
  end

  assign word_o = hold_q;
endmodule

// File: rtl/shl_field_decode.sv
module shl_field_decode
  import shl_pkg::*;
#(
  parameter int NPH = NUM_PH
) (
  input  logic [WORD_W-1:0]           word_i,
  input  logic                        force_off_i,
  output logic [TQ_W-1:0]             tq_o,
  output logic [PCT_W-1:0]            tq_pct_o,
  output logic [NPH-1:0][CUR_W-1:0]   cur_o,
  output logic [NPH-1:0]              dec_o,
  output logic [NPH-1:0]              mix_o,
  output logic [NPH-1:0][PCT_W-1:0]   mix_pct_o,
  output logic [NPH-1:0]              pol_o,
  output logic [NPH-1:0]              off_o
);
  word_t                  w;
  phase_t [NPH-1:0]       ph;

  assign w        = force_off_i ? word_t'('0) : word_t'(word_i);
  assign tq_o     = w.tq;
  assign tq_pct_o = torque_pct(w.tq);
  // index 0 = phase A, 1 = phase B
  assign ph[0]    = w.ph_a;
  assign ph[1]    = w.ph_b;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    assign cur_o[p]     = ph[p].cur;
    assign dec_o[p]     = ph[p].dec;
    assign mix_o[p]     = ph[p].mix;
    assign mix_pct_o[p] = mix_pct(ph[p].mix);
    assign pol_o[p]     = ph[p].pol;
    assign off_o[p]     = ~|ph[p].cur;
  end
endmodule

// File: rtl/shl_serial_latch.sv
module shl_serial_latch
  import shl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             sclk_i,
  input  logic             strobe_i,
  input  logic             thermal_i,
  output logic [TQ_W-1:0]  torque_o,
  output logic [PCT_W-1:0] torque_pct_o,
  output logic [CUR_W-1:0] cur_a_o,
  output logic             decay_a_o,
  output logic             mix_a_o,
  output logic [PCT_W-1:0] mix_pct_a_o,
  output logic             pol_a_o,
  output logic             off_a_o,
  output logic [CUR_W-1:0] cur_b_o,
  output logic             decay_b_o,
  output logic             mix_b_o,
  output logic [PCT_W-1:0] mix_pct_b_o,
  output logic             pol_b_o,
  output logic             off_b_o
);
  logic                          sclk_rise, strobe_rise;
  logic [WORD_W-1:0]             sr_word, hold_word;
  logic [NUM_PH-1:0][CUR_W-1:0]  cur;
  logic [NUM_PH-1:0][PCT_W-1:0]  mpct;
  logic [NUM_PH-1:0]             dec, mix, pol, off;

  shl_edge_det u_sclk_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(sclk_i), .rise_o(sclk_rise)
  );

  shl_edge_det u_strobe_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(strobe_i), .rise_o(strobe_rise)
  );

  shl_shift_reg #(.WORD_W(WORD_W)) u_shift (
    .clk_i (clk_i), .rst_ni(rst_ni), .shift_i(sclk_rise),
    .data_i(sdata_i), .word_o(sr_word)
  );

  shl_hold_latch #(.WORD_W(WORD_W)) u_hold (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(strobe_rise),
    .freeze_i(thermal_i), .word_i(sr_word), .word_o(hold_word)
  );

  shl_field_decode #(.NPH(NUM_PH)) u_dec (
    .word_i     (hold_word),
    .force_off_i(thermal_i | ~rst_ni),
    .tq_o       (torque_o),
    .tq_pct_o   (torque_pct_o),
    .cur_o      (cur),
    .dec_o      (dec),
    .mix_o      (mix),
    .mix_pct_o  (mpct),
    .pol_o      (pol),
    .off_o      (off)
  );

  assign cur_a_o     = cur[0];
  assign decay_a_o   = dec[0];
  assign mix_a_o     = mix[0];
  assign mix_pct_a_o = mpct[0];
  assign pol_a_o     = pol[0];
  assign off_a_o     = off[0];
  assign cur_b_o     = cur[1];
  assign decay_b_o   = dec[1];
  assign mix_b_o     = mix[1];
  assign mix_pct_b_o = mpct[1];
  assign pol_b_o     = pol[1];
  assign off_b_o     = off[1];
endmodule

// File: rtl/shl_serial_latch_chk.sv
module shl_serial_latch_chk
  import shl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sdata_i,
  input logic              thermal_i,
  input logic              sclk_rise,
  input logic              strobe_rise,
  input logic [WORD_W-1:0] sr_word,
  input logic [WORD_W-1:0] hold_word,
  input logic [PCT_W-1:0]  torque_pct_o,
  input logic [CUR_W-1:0]  cur_a_o,
  input logic [CUR_W-1:0]  cur_b_o,
  input logic              off_a_o,
  input logic              off_b_o
);
  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_off: assert (off_a_o && off_b_o && cur_a_o == '0 && cur_b_o == '0
                              && torque_pct_o == PCT_W'(50));
    end
  end

  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> sr_word[WORD_W-1] == $past(sdata_i));

  a_r3_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_rise |=> $stable(hold_word));

  a_r5_thermal_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_i |-> (off_a_o && off_b_o && cur_a_o == '0 && cur_b_o == '0));

  a_r6_thermal_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_i |=> $stable(hold_word));

  a_r7_pct_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    torque_pct_o inside {PCT_W'(50), PCT_W'(70), PCT_W'(85), PCT_W'(100)});

  a_r8_nonzero_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_a_o != '0) |-> !off_a_o);
endmodule

bind shl_serial_latch shl_serial_latch_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sdata_i     (sdata_i),
  .thermal_i   (thermal_i),
  .sclk_rise   (sclk_rise),
  .strobe_rise (strobe_rise),
  .sr_word     (sr_word),
  .hold_word   (hold_word),
  .torque_pct_o(torque_pct_o),
  .cur_a_o     (cur_a_o),
  .cur_b_o     (cur_b_o),
  .off_a_o     (off_a_o),
  .off_b_o     (off_b_o)
);

// File: tb/shl_serial_latch_test.sv
`timescale 1ns/1ps
module shl_serial_latch_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sdata_i = 1'b0, sclk_i = 1'b0, strobe_i = 1'b0, thermal_i = 1'b0;
  logic [1:0] torque_o;
  logic [6:0] torque_pct_o, mix_pct_a_o, mix_pct_b_o;
  logic [3:0] cur_a_o, cur_b_o;
  logic decay_a_o, mix_a_o, pol_a_o, off_a_o;
  logic decay_b_o, mix_b_o, pol_b_o, off_b_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  shl_serial_latch uut (.*);

  function automatic logic [6:0] tq_pct(input logic [1:0] c);
    case (c)
      2'b11: return 7'd100;
      2'b10: return 7'd85;
      2'b01: return 7'd70;
      default: return 7'd50;
    endcase
  endfunction

  // R10 layout, computed from bit positions
  function automatic logic [38:0] expect_vec(input logic [15:0] w, input bit forced);
    logic [15:0] v;
    v = forced ? 16'h0 : w;
    return {v[1:0], tq_pct(v[1:0]),
            v[14:11], v[10], v[9], (v[9] ? 7'd74 : 7'd40), v[15], (v[14:11] == 4'd0),
            v[7:4], v[3], v[2], (v[2] ? 7'd74 : 7'd40), v[8], (v[7:4] == 4'd0)};
  endfunction

  function automatic logic [38:0] actual_vec();
    return {torque_o, torque_pct_o,
            cur_a_o, decay_a_o, mix_a_o, mix_pct_a_o, pol_a_o, off_a_o,
            cur_b_o, decay_b_o, mix_b_o, mix_pct_b_o, pol_b_o, off_b_o};
  endfunction

  task automatic check_out(input logic [15:0] w, input bit forced, input string req);
    logic [38:0] e, a;
    e = expect_vec(w, forced);
    a = actual_vec();
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, a, e);
    end
  endtask

  task automatic send_bits(input logic [31:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sdata_i = b[i];
      @(negedge clk_i);
      sclk_i = 1'b1;
      @(negedge clk_i); @(negedge clk_i);
      sclk_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  task automatic pulse_strobe();
    @(negedge clk_i); strobe_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i); strobe_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
  endtask

  task automatic load_word(input logic [15:0] w);
    send_bits({16'h0, w}, 16);
    pulse_strobe();
  endtask

  task automatic t_reset();
    #1 check_out(16'h0, 1'b1, "R1 during reset");
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check_out(16'h0, 1'b0, "R1 after release");
  endtask

  task automatic t_basic();
    load_word(16'hB6D5);
    check_out(16'hB6D5, 1'b0, "R2 R10 word A");
    load_word(16'h2C3A);
    check_out(16'h2C3A, 1'b0, "R2 R10 word B");
  endtask

  task automatic t_strobe_level();
    send_bits({16'h0, 16'h9F61}, 16);
    check_out(16'h2C3A, 1'b0, "R3 shift without strobe");
    @(negedge clk_i); strobe_i = 1'b1;
    send_bits({16'h0, 16'h5E83}, 16);
    check_out(16'h9F61, 1'b0, "R3 rise latched prior word");
    send_bits({16'h0, 16'h7777}, 16);
    check_out(16'h9F61, 1'b0, "R3 held strobe level");
    strobe_i = 1'b0;
    pulse_strobe();
    check_out(16'h7777, 1'b0, "R3 next rise");
  endtask

  task automatic t_torque();
    for (int c = 0; c < 4; c++) begin
      load_word(16'h3C50 | 16'(c));
      check_out(16'h3C50 | 16'(c), 1'b0, "R7 torque code");
    end
  endtask

  task automatic t_zero_cur();
    load_word(16'h8172);
    check_out(16'h8172, 1'b0, "R8 phase A zero");
    load_word(16'h7A0D);
    check_out(16'h7A0D, 1'b0, "R8 phase B zero");
  endtask

  task automatic t_mix();
    load_word(16'h4A78);
    check_out(16'h4A78, 1'b0, "R9 A74 B40");
    load_word(16'h4874);
    check_out(16'h4874, 1'b0, "R9 A40 B74");
  endtask

  task automatic t_overrun();
    send_bits({12'h0, 16'hE1C9, 4'hB}, 20);
    pulse_strobe();
    check_out(16'hE1C9, 1'b0, "R4 last 16 bits");
  endtask

  task automatic t_thermal();
    load_word(16'hD3B6);
    @(negedge clk_i); thermal_i = 1'b1;
    #1 check_out(16'hD3B6, 1'b1, "R5 forced off");
    load_word(16'h6A5F);
    check_out(16'h6A5F, 1'b1, "R5 still off");
    @(negedge clk_i); thermal_i = 1'b0;
    @(negedge clk_i);
    check_out(16'hD3B6, 1'b0, "R6 frozen word returns");
    pulse_strobe();
    check_out(16'h6A5F, 1'b0, "R6 shift kept during fault");
  endtask

  task automatic t_reset_mid();
    @(negedge clk_i); rst_ni = 1'b0;
    #1 check_out(16'h0, 1'b1, "R1 async reset");
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check_out(16'h0, 1'b0, "R1 latch cleared");
    pulse_strobe();
    check_out(16'h0, 1'b0, "R1 shift cleared");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_strobe_level();
    t_torque();
    t_zero_cur();
    t_mix();
    t_overrun();
    t_thermal();
    t_reset_mid();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule